// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns the full `2*WIDTH`-bit product. It does not build one shifted row for every multiplier bit. Instead it walks the multiplier in overlapping three-bit windows, two bit positions apart, and turns each window into a small control word. That word picks the row's multiple of the multiplicand: zero, one times, or two times, with an optional negation. This gives `WIDTH/2` rows, and no row ever needs three times the multiplicand.

Each row is negated by bitwise inversion. The missing +1 is placed as a single bit at the row's lowest column. Rows are not sign-extended across the full product width. Instead, each row's sign bit is flipped, and one precomputed constant word repairs the total. A chain of 3:2 carry-save stages sums the rows, the negation bits and the constant, and one carry-propagate adder finishes the result.

The product can be taken straight from the adder or through one output register, which a parameter selects. `WIDTH` must be even.

Top module: `r4_mult`

## Requirements
- R1: For every pair of signed `WIDTH`-bit operands, `product_o` equals their exact signed product as a `2*WIDTH`-bit two's-complement value, including its sign bit.
- R2: Each window of multiplier bits (high, middle, low) selects a multiple of the multiplicand. Windows 000 and 111 select zero, 001 and 010 select +1, 011 selects +2, 100 selects -2, and 101 and 110 select -1. Row i carries weight 4^i.
- R3: The low bit of the first window is a constant 0. A multiplier of 1 therefore yields the multiplicand, sign-extended.
- R4: Operands at the most negative value (-2^(WIDTH-1)) on either input or on both inputs give the exact product. The product of both is the positive value 2^(2*WIDTH-2).
- R5: With `OUT_REG=1`, `product_o` shows the product of the operands present at the previous rising clock edge, and holds its old value until that edge. `rst` high at a rising edge clears `product_o` to zero at that edge.
- R6: A zero on either operand gives a zero product, whatever the other operand is.
- R7: With `OUT_REG=0`, `product_o` follows the operands with no clock edge in between. At `WIDTH=4` it is correct for all 256 operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mplier_i | input | WIDTH | Signed multiplier, the operand that is recoded |
| mcand_i | input | WIDTH | Signed multiplicand, the operand that is selected into rows |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The block holds no state apart from the output register. A wrong recode, a dropped negation bit or a bad compensation constant therefore shows up as a wrong product on the very next sample: at the following edge with the register, at once without it. The two's-complement wrap makes many of these faults show only for certain operand patterns. The bench therefore sweeps every window code, the extreme negative operands and the whole 4-bit operand space. A stuck or late output register is visible as a product that arrives one cycle off, or that is not cleared by reset.

// File: rtl/r4_mult_pkg.sv
package r4_mult_pkg;

    // Control word for one partial-product row.
    typedef struct packed {
        logic one;   // select the multiplicand itself
        logic two;   // select the multiplicand shifted left by one
        logic neg;   // invert the selection and add one at the row LSB
    } recode_t;

    // Turn a three-bit multiplier window {high, mid, low} into row controls.
    function automatic recode_t recode_group(input logic [2:0] g);
        recode_t r;
        r.one = g[1] ^ g[0];
        r.two = (g == 3'b011) || (g == 3'b100);
        r.neg = g[2];
        return r;
    endfunction

    // Row count for an even operand width.
    function automatic int row_count(input int width);
        return width / 2;
    endfunction

endpackage

// File: rtl/r4_recoder.sv
module r4_recoder
    import r4_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]                   mplier,
    output recode_t [row_count(WIDTH)-1:0]     ctl
);
    localparam int ROWS = row_count(WIDTH);

    // Multiplier with an implied zero below bit 0.
    logic [WIDTH:0] ext;
    assign ext = {mplier, 1'b0};

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign ctl[r] = recode_group(ext[2*r+2 -: 3]);

        always_comb begin
            // R2: a row never selects both magnitudes at once
            p_mag_exclusive_r2: assert (!(ctl[r].one && ctl[r].two));
        end
    end

endmodule

// File: rtl/r4_pp_select.sv
module r4_pp_select
    import r4_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] mcand,
    input  recode_t          ctl,
    output logic [WIDTH:0]   pp
);
    localparam int PPW = WIDTH + 1;

    logic [PPW-1:0] mult;

    always_comb begin
        if (ctl.one)
            mult = {mcand[WIDTH-1], mcand};
        else if (ctl.two)
            mult = {mcand, 1'b0};
        else
            mult = '0;
        pp = mult ^ {PPW{ctl.neg}};
    end

    always_comb begin
        if (!ctl.one && !ctl.two) begin
            // R2: zero selection leaves only the inversion pattern
            p_zero_row_r2: assert (pp == {PPW{ctl.neg}});
        end
        if (ctl.one) begin
            // R2: single multiple keeps the operand sign, flipped when negated
            p_single_sign_r2: assert (pp[WIDTH] == (mcand[WIDTH-1] ^ ctl.neg));
        end
    end

endmodule

// File: rtl/r4_csa_sum.sv
module r4_csa_sum
    import r4_mult_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  recode_t [row_count(WIDTH)-1:0]           ctl,
    input  logic    [row_count(WIDTH)-1:0][WIDTH:0]  pps,
    output logic    [2*WIDTH-1:0]                    sum
);
    localparam int ROWS = row_count(WIDTH);
    localparam int PW   = 2 * WIDTH;
    localparam int NOPS = ROWS + 2;
    localparam int NSTG = NOPS - 2;

    // Sum of -2^(WIDTH+2r) over all rows: repairs the flipped sign bits.
    function automatic logic [PW-1:0] comp_const();
        logic [PW-1:0] acc;
        acc = '0;
        for (int r = 0; r < ROWS; r++)
            acc = acc - (PW'(1) << (WIDTH + 2 * r));
        return acc;
    endfunction

    localparam logic [PW-1:0] COMP = comp_const();

    logic [PW-1:0] ops [NOPS];

    always_comb begin
        for (int k = 0; k < NOPS; k++)
            ops[k] = '0;
        for (int r = 0; r < ROWS; r++) begin
            ops[r] = PW'({~pps[r][WIDTH], pps[r][WIDTH-1:0]}) << (2 * r);
            ops[ROWS][2*r] = ctl[r].neg;
        end
        ops[ROWS+1] = COMP;
    end

    logic [PW-1:0] s_v [NSTG+1];
    logic [PW-1:0] c_v [NSTG+1];

    assign s_v[0] = ops[0];
    assign c_v[0] = ops[1];

    for (genvar k = 0; k < NSTG; k++) begin : g_csa
        assign s_v[k+1] = s_v[k] ^ c_v[k] ^ ops[k+2];
        assign c_v[k+1] = ((s_v[k] & c_v[k]) | (s_v[k] & ops[k+2]) |
                           (c_v[k] & ops[k+2])) << 1;

        always_comb begin
            // R1: each compressor stage preserves the running total
            p_csa_preserve_r1: assert ((s_v[k+1] + c_v[k+1]) ==
                                       (s_v[k] + c_v[k] + ops[k+2]));
        end
    end

    assign sum = s_v[NSTG] + c_v[NSTG];

endmodule

// File: rtl/r4_mult.sv
module r4_mult
    import r4_mult_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WIDTH-1:0]     mplier_i,
    input  logic [WIDTH-1:0]     mcand_i,
    output logic [2*WIDTH-1:0]   product_o
);
    localparam int ROWS = row_count(WIDTH);
    localparam int PW   = 2 * WIDTH;

    recode_t [ROWS-1:0]           ctl;
    logic    [ROWS-1:0][WIDTH:0]  pps;
    logic    [PW-1:0]             prod_comb;

    r4_recoder #(.WIDTH(WIDTH)) i_recoder (
        .mplier (mplier_i),
        .ctl    (ctl)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_sel
        r4_pp_select #(.WIDTH(WIDTH)) i_sel (
            .mcand (mcand_i),
            .ctl   (ctl[r]),
            .pp    (pps[r])
        );
    end

    r4_csa_sum #(.WIDTH(WIDTH)) i_sum (
        .ctl (ctl),
        .pps (pps),
        .sum (prod_comb)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                product_o <= '0;
            else
                product_o <= prod_comb;
        end

        // R5: reset empties the output register
        p_reset_clear_r5: assert property (@(posedge clk)
            rst |=> (product_o == '0));

        // R6: zero multiplier gives zero product one cycle later
        p_zero_mplier_r6: assert property (@(posedge clk) disable iff (rst)
            (mplier_i == '0) |=> (product_o == '0));

        // R6: zero multiplicand gives zero product one cycle later
        p_zero_mcand_r6: assert property (@(posedge clk) disable iff (rst)
            (mcand_i == '0) |=> (product_o == '0));

        // R1: product sign matches operand signs for nonzero operands
        p_sign_r1: assert property (@(posedge clk) disable iff (rst)
            ((mplier_i != '0) && (mcand_i != '0)) |=>
            (product_o[PW-1] == $past(mplier_i[WIDTH-1] ^ mcand_i[WIDTH-1])));
    end else begin : g_comb
        assign product_o = prod_comb;
    end

endmodule

// File: tb/test_r4_mult.sv
`timescale 1ns/1ps
module test_r4_mult;

    localparam int W  = 8;
    localparam int W4 = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [W-1:0]    mplier = '0;
    logic [W-1:0]    mcand  = '0;
    logic [2*W-1:0]  product;
    logic [W4-1:0]   mplier4 = '0;
    logic [W4-1:0]   mcand4  = '0;
    logic [2*W4-1:0] product4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    r4_mult #(.WIDTH(W), .OUT_REG(1'b1)) i_r4_mult (
        .clk       (clk),
        .rst       (rst),
        .mplier_i  (mplier),
        .mcand_i   (mcand),
        .product_o (product)
    );

    r4_mult #(.WIDTH(W4), .OUT_REG(1'b0)) i_r4_mult_w4 (
        .clk       (clk),
        .rst       (rst),
        .mplier_i  (mplier4),
        .mcand_i   (mcand4),
        .product_o (product4)
    );

    function automatic logic [2*W-1:0] ref8(input logic [W-1:0] a, input logic [W-1:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[2*W-1:0];
    endfunction

    function automatic logic [2*W4-1:0] ref4(input logic [W4-1:0] a, input logic [W4-1:0] b);
        int p;
        p = int'($signed(a)) * int'($signed(b));
        return p[2*W4-1:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, check.
    task automatic run8(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
        mplier = a;
        mcand  = b;
        @(negedge clk);
        chk(req, 32'(product), 32'(ref8(a, b)));
    endtask

    initial begin
        void'($urandom(32'd4242));
        mplier = 8'h05;
        mcand  = 8'h07;
        repeat (2) @(negedge clk);
        chk("R5 reset", 32'(product), 32'd0);
        rst = 1'b0;

        // R3: multiplier of one returns the multiplicand
        run8("R3", 8'h01, 8'hDB);
        run8("R3", 8'h01, 8'h7F);

        // R2: patterns that hit every window code
        run8("R2", 8'h02, 8'h13);
        run8("R2", 8'h03, 8'hA5);
        run8("R2", 8'hFF, 8'h3C);
        run8("R2", 8'hFE, 8'h81);
        run8("R2", 8'hFD, 8'h6E);
        run8("R2", 8'h55, 8'hC9);
        run8("R2", 8'hAA, 8'h47);
        run8("R2", 8'h6C, 8'hF1);
        run8("R2", 8'h93, 8'h2B);

        // R4: extreme negative operands
        run8("R4", 8'h80, 8'h80);
        run8("R4", 8'h80, 8'h7F);
        run8("R4", 8'h7F, 8'h80);
        run8("R4", 8'h80, 8'h01);
        run8("R4", 8'h80, 8'hFF);
        run8("R4", 8'h7F, 8'h7F);

        // R6: zero operand
        run8("R6", 8'h00, 8'h9D);
        run8("R6", 8'hB7, 8'h00);
        run8("R6", 8'h80, 8'h00);

        // R5: output holds until the edge, then updates
        mplier = 8'h11;
        mcand  = 8'h22;
        @(negedge clk);
        mplier = 8'hE3;
        mcand  = 8'h35;
        #1;
        chk("R5 hold", 32'(product), 32'(ref8(8'h11, 8'h22)));
        @(negedge clk);
        chk("R5 update", 32'(product), 32'(ref8(8'hE3, 8'h35)));

        // R5: reset in mid-run with nonzero operands
        rst = 1'b1;
        @(negedge clk);
        chk("R5 midreset", 32'(product), 32'd0);
        rst = 1'b0;

        // R1: random operands
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            a = W'($urandom);
            b = W'($urandom);
            run8("R1", a, b);
        end

        // R7: exhaustive 4-bit, combinational variant
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                mplier4 = W4'(a);
                mcand4  = W4'(b);
                #1;
                chk("R7", 32'(product4), 32'(ref4(W4'(a), W4'(b))));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule